// File: doc/BRIEF.md
# Edge Change Interrupt Controller

This block watches a bank of digital inputs and raises a single level interrupt when a selected transition appears on any of them. Each input is brought into the clock domain through a short synchronizer chain. Each synchronized sample is compared with the one taken a clock earlier. Two per-channel masks pick which channels may report a rising transition and which may report a falling one. Two global polarity enables in the control register gate those masks.

A selected transition sets a sticky edge flag. If another transition arrives before that flag is cleared, an overflow flag is set as well. Each flag has its own interrupt enable, and a master enable gates both. The interrupt line can be shared with other sources. Software therefore claims an interrupt only when it sees the master-pending bit and the edge bit both set. It then clears the flags by writing ones to a separate clear register.

Registers are reached through a byte-wide write port and a combinational read port addressed by a 6-bit offset.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every mask byte, the control register (offset 0x15) and the status register (offset 0x14) read 0x00, and `irq` is low.
- R2: The rising mask is held at offsets 0x18, 0x19, 0x1A and the falling mask at 0x20, 0x21, 0x22, least significant byte first, with channel n at bit n. Both masks read back what was written. The control register reads back only its low five bits, and the upper three bits read as zero.
- R3: A 0-to-1 transition on channel n sets the edge flag (status bit 0) when rising-mask bit n and control bit 3 are both set. A 1-to-0 transition sets it when falling-mask bit n and control bit 4 are both set.
- R4: A transition whose polarity mask bit for that channel is clear, or whose global polarity enable (control bit 3 for rising, bit 4 for falling) is clear, leaves the status unchanged.
- R5: A selected transition that arrives while the edge flag is already set also sets the overflow flag (status bit 1).
- R6: Writing offset 0x07 with bit 3 set clears the edge flag, and writing it with bit 2 set clears the overflow flag. The two clears act independently.
- R7: A selected transition in the same cycle as a clear write leaves the edge flag set afterwards, so the event is not lost.
- R8: Status bit 2 and `irq` both equal control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)).
- R9: With the control register at 0x00, `irq` stays low even when flags are set.
- R10: Writes to the status offset change nothing. Writes to 0x07 with bits 2 and 3 clear change no flag. Reads of 0x07 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NUM_CH | Asynchronous digital inputs |
| reg_addr | input | 6 | Register byte offset for write and read |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Active-high level interrupt |

## Verification
The bench builds the block with its default 24 channels and a two-stage synchronizer, so every mask bit in all three bytes of both masks is reached. On that configuration it sweeps every channel in both polarities, with both the matching and the opposite mask bit. It also walks all 32 control values against all four combinations of the edge and overflow flags and compares `irq` with the formula. A transition is timed to land in the very cycle of a clear write, which exercises the no-loss rule at its boundary.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // register offsets (software decodes these)
    localparam logic [5:0] OFS_CLEAR  = 6'h07;
    localparam logic [5:0] OFS_STATUS = 6'h14;
    localparam logic [5:0] OFS_CTRL   = 6'h15;
    localparam logic [5:0] OFS_RISE   = 6'h18;
    localparam logic [5:0] OFS_FALL   = 6'h20;

    // clear register bit positions
    localparam int CLR_OVF_BIT  = 2;
    localparam int CLR_EDGE_BIT = 3;

    // control byte, bit 4 down to bit 0
    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic master_en;
        logic ovf_ie;
        logic edge_ie;
    } ctrl_t;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int NUM_CH = 24,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][NUM_CH-1:0] pipe;
        logic [NUM_CH-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.pipe[STAGES-1] & st_q.prev;

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int NUM_CH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic [7:0]        status_i,
    output logic [NUM_CH-1:0] rise_mask_o,
    output logic [NUM_CH-1:0] fall_mask_o,
    output ctrl_t             ctrl_o,
    output logic              clr_edge_o,
    output logic              clr_ovf_o,
    output logic [7:0]        reg_rdata
);
    localparam int NBYTES = NUM_CH / 8;

    typedef struct packed {
        logic [NBYTES-1:0][7:0] rise;
        logic [NBYTES-1:0][7:0] fall;
        ctrl_t                  ctrl;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (reg_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (reg_addr == OFS_RISE + 6'(b)) rg_d.rise[b] = reg_wdata;
                if (reg_addr == OFS_FALL + 6'(b)) rg_d.fall[b] = reg_wdata;
            end
            if (reg_addr == OFS_CTRL) rg_d.ctrl = ctrl_t'(reg_wdata[4:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == OFS_STATUS) reg_rdata = status_i;
        if (reg_addr == OFS_CTRL)   reg_rdata = {3'b000, rg_q.ctrl};
        for (int b = 0; b < NBYTES; b++) begin
            if (reg_addr == OFS_RISE + 6'(b)) reg_rdata = rg_q.rise[b];
            if (reg_addr == OFS_FALL + 6'(b)) reg_rdata = rg_q.fall[b];
        end
    end

    assign clr_edge_o  = reg_wr && (reg_addr == OFS_CLEAR) && reg_wdata[CLR_EDGE_BIT];
    assign clr_ovf_o   = reg_wr && (reg_addr == OFS_CLEAR) && reg_wdata[CLR_OVF_BIT];
    assign rise_mask_o = rg_q.rise;
    assign fall_mask_o = rg_q.fall;
    assign ctrl_o      = rg_q.ctrl;

endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags
    import edge_irq_pkg::*;
#(
    parameter int NUM_CH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rise_i,
    input  logic [NUM_CH-1:0] fall_i,
    input  logic [NUM_CH-1:0] rise_mask_i,
    input  logic [NUM_CH-1:0] fall_mask_i,
    input  ctrl_t             ctrl_i,
    input  logic              clr_edge_i,
    input  logic              clr_ovf_i,
    output logic              event_o,
    output logic              edge_flag_o,
    output logic              ovf_flag_o,
    output logic              pend_o
);
    typedef struct packed {
        logic edge_flag;
        logic ovf_flag;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   evt;

    always_comb begin
        evt = (ctrl_i.rise_en && |(rise_i & rise_mask_i))
           || (ctrl_i.fall_en && |(fall_i & fall_mask_i));
        fl_d           = fl_q;
        // a new event wins over a clear in the same cycle
        fl_d.edge_flag = (fl_q.edge_flag && !clr_edge_i) || evt;
        fl_d.ovf_flag  = (fl_q.ovf_flag && !clr_ovf_i) || (evt && fl_q.edge_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign event_o     = evt;
    assign edge_flag_o = fl_q.edge_flag;
    assign ovf_flag_o  = fl_q.ovf_flag;
    assign pend_o      = ctrl_i.master_en
                      && ((fl_q.edge_flag && ctrl_i.edge_ie) || (fl_q.ovf_flag && ctrl_i.ovf_ie));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_CH      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    input  logic [5:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [NUM_CH-1:0] rise, fall, rise_mask, fall_mask;
    ctrl_t             ctrl;
    logic              clr_edge, clr_ovf, evt;
    logic              edge_flag, ovf_flag, pend;
    logic [7:0]        status;

    assign status = {5'b00000, pend, ovf_flag, edge_flag};

    edge_irq_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .rise_o (rise),
        .fall_o (fall)
    );

    edge_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .status_i    (status),
        .rise_mask_o (rise_mask),
        .fall_mask_o (fall_mask),
        .ctrl_o      (ctrl),
        .clr_edge_o  (clr_edge),
        .clr_ovf_o   (clr_ovf),
        .reg_rdata   (reg_rdata)
    );

    edge_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .rise_mask_i (rise_mask),
        .fall_mask_i (fall_mask),
        .ctrl_i      (ctrl),
        .clr_edge_i  (clr_edge),
        .clr_ovf_i   (clr_ovf),
        .event_o     (evt),
        .edge_flag_o (edge_flag),
        .ovf_flag_o  (ovf_flag),
        .pend_o      (pend)
    );

    assign irq = pend;

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       edge_flag,
    input logic       ovf_flag,
    input logic       evt,
    input logic       clr_edge,
    input logic [4:0] ctrl_bits
);
    p_event_sets_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> edge_flag);

    p_ovf_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(edge_flag) && $past(evt)));

    p_clear_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_edge && !evt) |=> !edge_flag);

    p_no_loss_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_edge && evt) |=> edge_flag);

    p_irq_needs_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_bits[2] && ((edge_flag && ctrl_bits[0]) || (ovf_flag && ctrl_bits[1]))));

    p_ctrl_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits == 5'd0) |-> !irq);
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .edge_flag (edge_flag),
    .ovf_flag  (ovf_flag),
    .evt       (evt),
    .clr_edge  (clr_edge),
    .ctrl_bits (ctrl)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    localparam int NCH = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] din = '0;
    logic [5:0]     reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic           irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    edge_irq_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_masks(input logic [23:0] rm, input logic [23:0] fm);
        for (int b = 0; b < 3; b++) begin
            wr(6'h18 + 6'(b), rm[b*8 +: 8]);
            wr(6'h20 + 6'(b), fm[b*8 +: 8]);
        end
    endtask

    task automatic drive(input logic [NCH-1:0] v);
        @(negedge clk);
        din = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(6'h07, 8'h0C);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        foreach (v[i]) begin end
        for (int b = 0; b < 3; b++) begin
            rd(6'h18 + 6'(b), v); chk("R1 rise mask", v, 0);
            rd(6'h20 + 6'(b), v); chk("R1 fall mask", v, 0);
        end
        rd(6'h15, v); chk("R1 control", v, 0);
        rd(6'h14, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);

        // R2: readback
        set_masks(24'hA5C31E, 24'h5A3CE1);
        for (int b = 0; b < 3; b++) begin
            rd(6'h18 + 6'(b), v); chk("R2 rise byte", v, (24'hA5C31E >> (8*b)) & 8'hFF);
            rd(6'h20 + 6'(b), v); chk("R2 fall byte", v, (24'h5A3CE1 >> (8*b)) & 8'hFF);
        end
        wr(6'h15, 8'hFF); rd(6'h15, v); chk("R2 control upper zero", v, 8'h1F);

        // R3/R4: per-channel sweep, both polarities enabled, interrupts off
        wr(6'h15, 8'h18);
        for (int ch = 0; ch < NCH; ch++) begin
            set_masks(24'(1) << ch, 24'h0);
            drive(din | (NCH'(1) << ch));
            rd(6'h14, v); chk("R3 rising sets edge", v, 8'h01);
            clear_all();
            rd(6'h14, v); chk("R6 clear after rise", v, 8'h00);
            drive(din & ~(NCH'(1) << ch));
            rd(6'h14, v); chk("R4 falling not selected", v, 8'h00);
            set_masks(24'h0, 24'(1) << ch);
            drive(din | (NCH'(1) << ch));
            rd(6'h14, v); chk("R4 rising not selected", v, 8'h00);
            drive(din & ~(NCH'(1) << ch));
            rd(6'h14, v); chk("R3 falling sets edge", v, 8'h01);
            clear_all();
        end

        // R4: global polarity enables gate the masks
        set_masks(24'hFFFFFF, 24'hFFFFFF);
        wr(6'h15, 8'h10);
        drive(24'h000001);
        rd(6'h14, v); chk("R4 rise global off", v, 8'h00);
        wr(6'h15, 8'h08);
        drive(24'h000000);
        rd(6'h14, v); chk("R4 fall global off", v, 8'h00);

        // R5/R6: overflow and independent clears
        drive(24'h000002);
        rd(6'h14, v); chk("R5 first event", v, 8'h01);
        drive(24'h000006);
        rd(6'h14, v); chk("R5 second event overflow", v, 8'h03);
        wr(6'h07, 8'h08);
        rd(6'h14, v); chk("R6 edge clear only", v, 8'h02);
        drive(24'h00000E);
        rd(6'h14, v); chk("R5 edge back, ovf kept", v, 8'h03);
        wr(6'h07, 8'h04);
        rd(6'h14, v); chk("R6 ovf clear only", v, 8'h01);
        clear_all();

        // R7: event lands in the cycle of the clear write
        drive(24'h00001E);
        rd(6'h14, v); chk("R7 setup", v, 8'h01);
        @(negedge clk);
        din = 24'h00003E;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 6'h07; reg_wdata = 8'h0C; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(6'h14, v); chk("R7 edge kept on clear", v & 8'h01, 8'h01);
        clear_all();

        // R8/R9: all control values against all flag combinations
        for (int combo = 0; combo < 4; combo++) begin
            logic e, o;
            wr(6'h15, 8'h08);
            clear_all();
            din = '0; repeat (4) @(negedge clk);
            clear_all();
            if (combo != 0) begin
                drive(24'h000001);
                if (combo >= 2) drive(24'h000003);
                if (combo == 3) wr(6'h07, 8'h08);
            end
            e = (combo == 1) || (combo == 2);
            o = (combo >= 2);
            for (int c = 0; c < 32; c++) begin
                logic p;
                wr(6'h15, 8'(c));
                p = c[2] && ((e && c[0]) || (o && c[1]));
                rd(6'h14, v);
                chk("R8 status pending", v, {5'b0, p, o, e});
                chk(c == 0 ? "R9 irq with control zero" : "R8 irq level", irq, p);
            end
        end

        // R9: dropping control to zero silences a live interrupt
        wr(6'h15, 8'h07);
        chk("R9 irq active before", irq, 1'b1);
        wr(6'h15, 8'h00);
        chk("R9 irq off after zero", irq, 1'b0);

        // R10: ignored writes and clear register readback (flags: ovf only)
        wr(6'h14, 8'hFF);
        rd(6'h14, v); chk("R10 status write ignored", v, 8'h02);
        wr(6'h07, 8'hF3);
        rd(6'h14, v); chk("R10 other clear bits ignored", v, 8'h02);
        rd(6'h07, v); chk("R10 clear reads zero", v, 8'h00);

        finish_run();
    end
endmodule